// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block lets a synchronous on-chip requester read and write an external asynchronous static RAM of 256K words by 16 bits. A request carries a read/write select, an 18-bit word address, 16-bit write data and a 2-bit lane mask. It is offered with a valid/ready handshake. A read returns its data on `rdData` together with a one-cycle `rdValid` pulse.

On the memory side the controller drives the address and four active-low strobes: chip select, output enable, write enable and one enable per byte lane. The data bus is split into an output word, an input word and a single drive-enable for the external tri-state buffer. Every pin is a flop output, so the strobes change only on clock edges.

The write pulse, the read access window and the bus turnaround each last a whole number of clock cycles. Each count is found by rounding a minimum time, given in picoseconds, up to a whole number of clock periods (at least one). The controller drives the data bus only while the memory's outputs are off, and it leaves a quiet gap after every read.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is asserted, `sramCeN`, `sramOeN`, `sramWeN`, `sramLbN` and `sramUbN` are high, `sramDqOe` is low, `rdValid` is low and `reqReady` is high.
- R2: A write holds `sramCeN` and `sramWeN` low together. Lane 0 (`sramLbN`, data bits 7:0) is enabled only if `reqMask[0]` is 1, and lane 1 (`sramUbN`, bits 15:8) only if `reqMask[1]` is 1. A lane whose mask bit is 0 keeps its stored value, and a mask of 00 writes nothing.
- R3: `sramWeN` stays low for exactly WP cycles, where WP = max(ceil(WRITE_PULSE_PS/CLK_PERIOD_PS), ceil(DATA_SETUP_PS/CLK_PERIOD_PS), 1). For the whole pulse `sramOeN` is high and `sramAddr`, `sramLbN` and `sramUbN` do not change.
- R4: `sramDqOe` is high in every cycle in which `sramWeN` is low and in the one cycle after it rises. It is low in the cycle after that.
- R5: A read holds `sramCeN` and `sramOeN` low with `sramWeN` high for RD = max(ceil(READ_ACCESS_PS/period), ceil(READ_CYCLE_PS/period), 1) cycles. The bus is sampled on the last of these cycles. A lane whose mask bit is 0 reads as zero.
- R6: Each read produces exactly one `rdValid` pulse, one cycle wide. It comes in the first cycle after the access window, and results come back in request order.
- R7: `sramDqOe` is never high while `sramOeN` is low. After a read ends, `sramOeN` stays high for at least TURN = max(ceil(TURNAROUND_PS/period), 1) cycles before the controller drives the bus again.
- R8: A request is accepted on a clock edge where `reqValid` and `reqReady` are both high. `reqReady` is then low for WP+1 cycles after a write, or RD+TURN cycles after a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Controller idle, request can be taken |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 18 | Word address |
| reqWdata | input | 16 | Write data |
| reqMask | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8, 1 = enabled |
| rdValid | output | 1 | Read data valid pulse |
| rdData | output | 16 | Read data, disabled lanes zero |
| sramAddr | output | 18 | Memory address |
| sramCeN | output | 1 | Chip select, active low |
| sramOeN | output | 1 | Output enable, active low |
| sramWeN | output | 1 | Write enable, active low |
| sramLbN | output | 1 | Lower lane enable, active low |
| sramUbN | output | 1 | Upper lane enable, active low |
| sramDqOut | output | 16 | Data toward the memory |
| sramDqIn | input | 16 | Data from the memory bus |
| sramDqOe | output | 1 | Drive enable for the bus buffer |

## Verification
The assertions assume that request fields stay stable while `reqValid` is high and `reqReady` is low. They also assume that `sramDqIn` is settled by the end of the access window. The bench's driver holds each request from the cycle it raises `reqValid` until the accepting edge. Its memory model updates the read word at the falling edge, well before the sampling edge, and it puts a fixed garbage byte on any lane the memory is not driving, so a wrong lane mask shows up.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  // strobes from the control FSM to the datapath (next-cycle pin values)
  typedef struct packed {
    logic ceN;
    logic oeN;
    logic weN;
    logic laneOn;
    logic drive;
    logic load;
    logic capture;
  } strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WPULSE,
    ST_WHOLD,
    ST_RACC,
    ST_TURN
  } ctrl_state_e;

  // whole clock cycles covering a minimum time, never below one
  function automatic int cyclesFor(input int minPs, input int periodPs);
    int c;
    c = (minPs + periodPs - 1) / periodPs;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int WP_CYC   = 1,
  parameter int RD_CYC   = 1,
  parameter int TURN_CYC = 1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output strobe_t stb
);

  localparam int MAX_CYC = maxOf(maxOf(WP_CYC, RD_CYC), TURN_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  ctrl_state_e state, nextState;
  logic [CNT_W-1:0] cnt;
  logic accept;
  logic lastWp, lastRd, lastTurn;

  assign accept   = (state == ST_IDLE) && reqValid;
  assign lastWp   = (cnt == CNT_W'(WP_CYC - 1));
  assign lastRd   = (cnt == CNT_W'(RD_CYC - 1));
  assign lastTurn = (cnt == CNT_W'(TURN_CYC - 1));

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:   if (reqValid) nextState = reqWrite ? ST_WPULSE : ST_RACC;
      ST_WPULSE: if (lastWp)   nextState = ST_WHOLD;
      ST_WHOLD:                nextState = ST_IDLE;
      ST_RACC:   if (lastRd)   nextState = ST_TURN;
      ST_TURN:   if (lastTurn) nextState = ST_IDLE;
      default:                 nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nextState;
      cnt   <= (nextState != state) ? '0 : cnt + 1'b1;
    end
  end

  // strobes describe the state being entered; the datapath registers them
  always_comb begin
    stb.ceN     = !((nextState == ST_WPULSE) || (nextState == ST_RACC));
    stb.weN     = !(nextState == ST_WPULSE);
    stb.oeN     = !(nextState == ST_RACC);
    stb.laneOn  = (nextState == ST_WPULSE) || (nextState == ST_RACC);
    stb.drive   = (nextState == ST_WPULSE) || (nextState == ST_WHOLD);
    stb.load    = accept;
    stb.capture = (state == ST_RACC) && lastRd;
  end

  assign reqReady = (state == ST_IDLE);

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady); // R8

  AST_CAPTURE_LEAVES_READ: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |=> (state == ST_TURN)); // R6

endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqMask,
  output logic [ADDR_W-1:0] sramAddr,
  output logic              sramCeN,
  output logic              sramOeN,
  output logic              sramWeN,
  output logic [LANES-1:0]  laneN,
  output logic [DATA_W-1:0] sramDqOut,
  input  logic [DATA_W-1:0] sramDqIn,
  output logic              sramDqOe,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);

  localparam int LANE_W = DATA_W / LANES;

  logic [LANES-1:0] maskQ, maskNext;

  assign maskNext = stb.load ? reqMask : maskQ;

  // request capture and control pins
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sramAddr  <= '0;
      sramDqOut <= '0;
      maskQ     <= '0;
      sramCeN   <= 1'b1;
      sramOeN   <= 1'b1;
      sramWeN   <= 1'b1;
      sramDqOe  <= 1'b0;
      rdValid   <= 1'b0;
    end else begin
      if (stb.load) begin
        sramAddr  <= reqAddr;
        sramDqOut <= reqWdata;
        maskQ     <= reqMask;
      end
      sramCeN  <= stb.ceN;
      sramOeN  <= stb.oeN;
      sramWeN  <= stb.weN;
      sramDqOe <= stb.drive;
      rdValid  <= stb.capture;
    end
  end

  // per-lane enables and read capture
  for (genvar g = 0; g < LANES; g++) begin : gLane
    always_ff @(posedge clk) begin
      if (!rstN) begin
        laneN[g]                   <= 1'b1;
        rdData[g*LANE_W +: LANE_W] <= '0;
      end else begin
        laneN[g] <= !(stb.laneOn && maskNext[g]);
        if (stb.capture)
          rdData[g*LANE_W +: LANE_W] <= maskQ[g] ? sramDqIn[g*LANE_W +: LANE_W] : '0;
      end
    end
  end

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rstN)
    sramDqOe |-> sramOeN); // R7

  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !sramWeN |-> sramOeN); // R3

  AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rstN)
    !sramWeN |-> !sramCeN); // R2

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !sramWeN && $past(!sramWeN) |-> $stable(sramAddr) && $stable(laneN)); // R3

  AST_DATA_TAIL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sramWeN) |-> sramDqOe); // R4

  AST_RDV_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid); // R6

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W         = 18,
  parameter int DATA_W         = 16,
  parameter int LANES          = 2,
  parameter int CLK_PERIOD_PS  = 20000,
  parameter int WRITE_PULSE_PS = 7000,
  parameter int DATA_SETUP_PS  = 4500,
  parameter int READ_ACCESS_PS = 10000,
  parameter int READ_CYCLE_PS  = 10000,
  parameter int TURNAROUND_PS  = 4000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqMask,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] sramAddr,
  output logic              sramCeN,
  output logic              sramOeN,
  output logic              sramWeN,
  output logic              sramLbN,
  output logic              sramUbN,
  output logic [DATA_W-1:0] sramDqOut,
  input  logic [DATA_W-1:0] sramDqIn,
  output logic              sramDqOe
);

  localparam int WP_CYC   = maxOf(cyclesFor(WRITE_PULSE_PS, CLK_PERIOD_PS),
                                  cyclesFor(DATA_SETUP_PS, CLK_PERIOD_PS));
  localparam int RD_CYC   = maxOf(cyclesFor(READ_ACCESS_PS, CLK_PERIOD_PS),
                                  cyclesFor(READ_CYCLE_PS, CLK_PERIOD_PS));
  localparam int TURN_CYC = cyclesFor(TURNAROUND_PS, CLK_PERIOD_PS);

  strobe_t stb;
  logic [LANES-1:0] laneN;

  sram_ctrl_fsm #(
    .WP_CYC  (WP_CYC),
    .RD_CYC  (RD_CYC),
    .TURN_CYC(TURN_CYC)
  ) uFsm (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .stb     (stb)
  );

  sram_ctrl_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LANES (LANES)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .reqMask  (reqMask),
    .sramAddr (sramAddr),
    .sramCeN  (sramCeN),
    .sramOeN  (sramOeN),
    .sramWeN  (sramWeN),
    .laneN    (laneN),
    .sramDqOut(sramDqOut),
    .sramDqIn (sramDqIn),
    .sramDqOe (sramDqOe),
    .rdValid  (rdValid),
    .rdData   (rdData)
  );

  assign sramLbN = laneN[0];
  assign sramUbN = laneN[LANES-1];

endmodule

// File: tb/tb_sram_async_ctrl.sv
`timescale 1ns/1ps
module tb_sram_async_ctrl;

  localparam int PERIOD_PS = 20000;
  localparam int WP_PS     = 27000;
  localparam int RA_PS     = 50000;
  localparam int TURN_PS   = 4000;
  localparam int WP   = (WP_PS + PERIOD_PS - 1) / PERIOD_PS;    // 2
  localparam int RD   = (RA_PS + PERIOD_PS - 1) / PERIOD_PS;    // 3
  localparam int TURN = (TURN_PS + PERIOD_PS - 1) / PERIOD_PS;  // 1

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [17:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqMask = '0;
  logic reqReady, rdValid;
  logic [15:0] rdData;
  logic [17:0] sramAddr;
  logic sramCeN, sramOeN, sramWeN, sramLbN, sramUbN, sramDqOe;
  logic [15:0] sramDqOut, sramDqIn;

  always #10 clk = ~clk;

  sram_async_ctrl #(
    .CLK_PERIOD_PS (PERIOD_PS),
    .WRITE_PULSE_PS(WP_PS),
    .READ_ACCESS_PS(RA_PS),
    .TURNAROUND_PS (TURN_PS)
  ) dut (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .rdValid(rdValid), .rdData(rdData),
    .sramAddr(sramAddr), .sramCeN(sramCeN), .sramOeN(sramOeN), .sramWeN(sramWeN),
    .sramLbN(sramLbN), .sramUbN(sramUbN),
    .sramDqOut(sramDqOut), .sramDqIn(sramDqIn), .sramDqOe(sramDqOe)
  );

  int tests = 0;
  int fails = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] fillPattern(input logic [17:0] a);
    return 16'(a * 7) ^ 16'hC35A;
  endfunction

  // memory model
  logic [15:0] mem [int];
  logic [15:0] memOut = '0;
  logic memDrvLo, memDrvHi;

  function automatic logic [15:0] memGet(input logic [17:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : fillPattern(a);
  endfunction

  assign memDrvLo = !sramCeN && !sramOeN && sramWeN && !sramLbN;
  assign memDrvHi = !sramCeN && !sramOeN && sramWeN && !sramUbN;
  assign sramDqIn = {memDrvHi ? memOut[15:8] : 8'hEE, memDrvLo ? memOut[7:0] : 8'hEE};

  always @(negedge clk) begin
    if (!sramCeN && !sramWeN) begin
      logic [15:0] w;
      w = memGet(sramAddr);
      if (!sramLbN) w[7:0]  = sramDqOut[7:0];
      if (!sramUbN) w[15:8] = sramDqOut[15:8];
      mem[int'(sramAddr)] = w;
    end
    memOut = memGet(sramAddr);
  end

  // reference memory and scoreboard
  logic [15:0] refMem [int];
  logic [15:0] expQ [$];

  function automatic logic [15:0] refGet(input logic [17:0] a);
    return refMem.exists(int'(a)) ? refMem[int'(a)] : fillPattern(a);
  endfunction

  task automatic doOp(input bit wr, input logic [17:0] a, input logic [15:0] d, input logic [1:0] m);
    int busy;
    int rdvAt;
    logic [15:0] r;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d; reqMask = m;
    r = refGet(a);
    if (wr) begin
      if (m[0]) r[7:0]  = d[7:0];
      if (m[1]) r[15:8] = d[15:8];
      refMem[int'(a)] = r;
    end else begin
      expQ.push_back({m[1] ? r[15:8] : 8'h00, m[0] ? r[7:0] : 8'h00});
    end
    @(negedge clk);
    reqValid = 1'b0;
    busy = 0;
    rdvAt = -1;
    while (!reqReady) begin
      busy++;
      if (rdValid && rdvAt < 0) rdvAt = busy;
      @(negedge clk);
    end
    check(busy == (wr ? WP + 1 : RD + TURN), "R8 busy cycles", busy, wr ? WP + 1 : RD + TURN);
    if (!wr) check(rdvAt == RD + 1, "R6 rdValid cycle", rdvAt, RD + 1);
  endtask

  // pin monitors
  int weRun = 0;
  bit tailSeen = 0;
  bit sawRead = 0;
  int gap = 0;
  bit prevRdv = 0;
  logic [17:0] prevAddr;
  logic [1:0]  prevLanes;

  always @(negedge clk) begin
    if (rstN) begin
      if (tailSeen) begin
        check(!sramDqOe, "R4 drive released", sramDqOe, 0);
        tailSeen = 0;
      end
      if (!sramWeN) begin
        weRun++;
        check(sramOeN && !sramCeN, "R2/R3 write strobes", {sramCeN, sramOeN}, 2'b01);
        check(sramDqOe, "R4 drive during pulse", sramDqOe, 1);
        if (weRun > 1)
          check(sramAddr == prevAddr && {sramUbN, sramLbN} == prevLanes, "R3 held",
                {sramAddr, sramUbN, sramLbN}, {prevAddr, prevLanes});
      end else if (weRun > 0) begin
        check(weRun == WP, "R3 pulse length", weRun, WP);
        check(sramDqOe, "R4 drive tail", sramDqOe, 1);
        weRun = 0;
        tailSeen = 1;
      end
      prevAddr  = sramAddr;
      prevLanes = {sramUbN, sramLbN};
      if (!sramOeN) begin
        check(sramWeN && !sramCeN && !sramDqOe, "R5/R7 read strobes",
              {sramCeN, sramWeN, sramDqOe}, 3'b010);
        sawRead = 1;
        gap = 0;
      end else if (sawRead) begin
        if (sramDqOe) begin
          check(gap >= TURN, "R7 turnaround", gap, TURN);
          sawRead = 0;
        end else gap++;
      end
      if (sramDqOe) check(!(memDrvLo || memDrvHi), "R7 contention", {memDrvHi, memDrvLo}, 0);
      if (rdValid) begin
        check(!prevRdv, "R6 single pulse", prevRdv, 0);
        if (expQ.size() == 0) check(0, "R6 unexpected rdValid", 1, 0);
        else begin
          logic [15:0] e;
          e = expQ.pop_front();
          check(rdData == e, "R5 read data", rdData, e);
        end
      end
      prevRdv = rdValid;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check({sramCeN, sramOeN, sramWeN, sramLbN, sramUbN} == 5'h1F && !sramDqOe && !rdValid && reqReady,
          "R1 reset state", {sramCeN, sramOeN, sramWeN, sramLbN, sramUbN, sramDqOe, rdValid, reqReady},
          8'b11111001);
    rstN = 1'b1;
    doOp(1, 18'h00010, 16'hBEEF, 2'b11);
    doOp(0, 18'h00010, 16'h0000, 2'b11);  // R5 full word
    doOp(1, 18'h00010, 16'h1234, 2'b10);  // R2 upper lane only
    doOp(0, 18'h00010, 16'h0000, 2'b11);
    doOp(1, 18'h00010, 16'hAA55, 2'b01);  // R2 lower lane only
    doOp(0, 18'h00010, 16'h0000, 2'b01);  // R5 upper reads zero
    doOp(0, 18'h00010, 16'h0000, 2'b10);  // R5 lower reads zero
    doOp(1, 18'h00010, 16'h0000, 2'b00);  // R2 no lanes written
    doOp(0, 18'h00010, 16'h0000, 2'b11);
    doOp(0, 18'h00010, 16'h0000, 2'b00);  // R5 both lanes zero
    doOp(0, 18'h3FFFF, 16'h0000, 2'b11);  // top address, untouched
    doOp(1, 18'h3FFFF, 16'h7E81, 2'b11);
    doOp(0, 18'h3FFFF, 16'h0000, 2'b11);
    for (int i = 0; i < 48; i++) begin
      logic [17:0] a;
      logic [1:0] m;
      a = 18'(i % 5) + 18'h00100;
      m = 2'((i * 3 + 1) % 4);
      doOp((i % 3) != 0, a, 16'(i * 16'h3D1) ^ 16'h5A5A, m);
    end
    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R6 every read answered", expQ.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule